// File: doc/BRIEF.md
# Three-Stage Pipeline Timing Controller

This block sequences a single-issue fetch/decode/execute pipeline. It presents the fetch address and moves instruction words from fetch into decode and from decode into execute. It holds the front stages while an instruction that needs more than one execute cycle is still working. When a branch executes, it discards the two younger instructions already in flight and restarts fetch at the branch target. The register file, shifter, ALU and real memory timing live elsewhere. The instruction memory is modelled as combinational: the word at `fetchAddr` appears on `instrWord` in the same cycle.

Every instruction carries a 2-bit class field. Data-processing instructions take one execute cycle, stores two, loads three, and branches three: target calculation, link write, then PC adjust. Every branch is taken. Outputs expose the fetch address, whether a fetch is accepted this cycle, the decode and execute valid flags, the execute sub-cycle index, a link-write strobe and a flush strobe.

Top module: `pipe3_seq`

## Requirements
- R1: A synchronous active-high `rst` forces `fetchAddr` to 0, `decodeValid`, `execValid` and `fetchEn` to 0. In the first cycle with `rst` low, `fetchEn` is 1 and `fetchAddr` is 0.
- R2: With no multi-cycle instruction in execute, `fetchEn` stays high and `fetchAddr` rises by 4 (one instruction) every cycle. The instruction accepted at address A reaches decode in the next cycle and execute in the cycle after that.
- R3: The class field is `instrWord[15:14]`: 00 data-processing, 01 store, 10 load, 11 branch. The branch offset is `instrWord[7:0]`, a signed count of instructions. The target is the branch's own address plus 4 times the offset.
- R4: A data-processing instruction occupies execute for one cycle, with `execSub` equal to 0.
- R5: A store occupies execute for two cycles, with `execSub` equal to 0 and then 1. While `execSub` is 0, `fetchEn` is low and `fetchAddr` holds.
- R6: A load occupies execute for three cycles, with `execSub` equal to 0, 1 and 2. `fetchEn` is low and `fetchAddr` holds while `execSub` is 0 or 1.
- R7: A branch occupies execute for three cycles. In sub-cycle 0, `fetchEn` is low. In sub-cycle 1, `fetchAddr` equals the target, `fetchEn` is high and `decodeValid` is low. In sub-cycle 2, `fetchAddr` is the target plus 4. The next instruction to enter execute is the one at the target.
- R8: `linkWrite` and `flush` are high only in sub-cycle 1 of a branch in execute.
- R9: A branch whose target is another branch executes the second branch with the same three-cycle sequence. No cycle is lost between the two branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instrWord | input | 16 | Instruction word read at `fetchAddr` |
| fetchAddr | output | 16 | Byte address of the instruction being fetched |
| fetchEn | output | 1 | Fetched word is accepted into decode this cycle |
| decodeValid | output | 1 | Decode stage holds a live instruction |
| execValid | output | 1 | Execute stage holds a live instruction |
| execSub | output | 2 | Execute sub-cycle index of the current instruction |
| linkWrite | output | 1 | Branch link-register write cycle |
| flush | output | 1 | Branch target presented; younger instructions discarded |

## Verification
The instruction image puts a run of data-processing instructions next to a store, a load and branches. Comparing every cycle against a reference model therefore tells a one-cycle hold apart from a two-cycle hold, and both apart from the branch's restart sequence. A branch that targets a branch, followed by a backward branch that loops the program, shows that the flush leaves no stale instruction in decode and that targets are computed from the branch's own address. Hand-derived checks on the first store hold and on both branch restarts pin down the exact cycles. A reset applied mid-run, then released, confirms that fetch restarts at zero.

// File: rtl/seq3_pkg.sv
package seq3_pkg;

  localparam int SUB_W = 2;

  typedef enum logic [1:0] {
    CLS_ALU    = 2'b00,
    CLS_STORE  = 2'b01,
    CLS_LOAD   = 2'b10,
    CLS_BRANCH = 2'b11
  } instr_cls_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic decAccept;  // decode takes the fetched word, pc steps
    logic execLoad;   // execute takes the decode contents
    logic redirect;   // pc <= branch target, decode discarded
    logic linkWr;
    logic flush;
  } seq_ctrl_t;

  // state reported by the datapath
  typedef struct packed {
    logic       dValid;
    logic       eValid;
    instr_cls_e eCls;
  } seq_stat_t;

  function automatic logic [SUB_W-1:0] lastSubOf(instr_cls_e c);
    case (c)
      CLS_ALU:   lastSubOf = SUB_W'(0);
      CLS_STORE: lastSubOf = SUB_W'(1);
      default:   lastSubOf = SUB_W'(2);
    endcase
  endfunction

endpackage

// File: rtl/seq3_datapath.sv
module seq3_datapath
  import seq3_pkg::*;
#(
  parameter int IW          = 16,
  parameter int AW          = 16,
  parameter int OFFW        = 8,
  parameter int INSTR_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] instrWord,
  input  seq_ctrl_t     ctrl,
  output seq_stat_t     stat,
  output logic [AW-1:0] fetchAddr
);

  localparam int          STEP_SHIFT = $clog2(INSTR_BYTES);
  localparam logic [AW-1:0] STEP     = AW'(INSTR_BYTES);

  logic [AW-1:0] pc;
  logic [AW-1:0] dAddr, eAddr;
  logic [IW-1:0] dWord, eWord;
  logic          dValid, eValid;
  logic [AW-1:0] offExt;
  logic [AW-1:0] target;

  always_comb begin
    offExt = {{(AW-OFFW){eWord[OFFW-1]}}, eWord[OFFW-1:0]};
    target = eAddr + (offExt << STEP_SHIFT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      dValid <= 1'b0;
      eValid <= 1'b0;
      dAddr  <= '0;
      eAddr  <= '0;
      dWord  <= '0;
      eWord  <= '0;
    end else begin
      if (ctrl.execLoad) begin
        eValid <= dValid;
        eWord  <= dWord;
        eAddr  <= dAddr;
      end
      if (ctrl.redirect) begin
        pc     <= target;
        dValid <= 1'b0;
      end else if (ctrl.decAccept) begin
        pc     <= pc + STEP;
        dWord  <= instrWord;
        dAddr  <= pc;
        dValid <= 1'b1;
      end
    end
  end

  always_comb begin
    stat.dValid = dValid;
    stat.eValid = eValid;
    stat.eCls   = instr_cls_e'(eWord[IW-1 -: 2]);
    fetchAddr   = pc;
  end

  // R1: reset clears the pipeline and rewinds fetch
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (pc == '0 && !dValid && !eValid));

  // R5, R6: a held front keeps both fetch address and decode word
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.decAccept && !ctrl.redirect) |=> ($stable(pc) && $stable(dWord)));

  // R7: the flush cycle finds decode already emptied
  p_flush_empty_decode_r7: assert property (@(posedge clk) disable iff (rst)
    ctrl.flush |-> !dValid);

endmodule

// File: rtl/seq3_control.sv
module seq3_control
  import seq3_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  seq_stat_t        stat,
  output seq_ctrl_t        ctrl,
  output logic [SUB_W-1:0] execSub,
  output logic             fetchEn
);

  logic [SUB_W-1:0] lastSub;
  logic             execDone;
  logic             isBranch;

  always_comb begin
    lastSub        = lastSubOf(stat.eCls);
    execDone       = !stat.eValid || (execSub == lastSub);
    isBranch       = stat.eValid && (stat.eCls == CLS_BRANCH);
    ctrl.execLoad  = execDone;
    ctrl.redirect  = isBranch && (execSub == SUB_W'(0));
    ctrl.decAccept = (!stat.dValid || execDone) && !ctrl.redirect;
    ctrl.linkWr    = isBranch && (execSub == SUB_W'(1));
    ctrl.flush     = isBranch && (execSub == SUB_W'(1));
    fetchEn        = !rst && ctrl.decAccept;
  end

  always_ff @(posedge clk) begin
    if (rst || execDone) execSub <= '0;
    else                 execSub <= execSub + SUB_W'(1);
  end

  // R6: the sub-cycle index never passes the class's last cycle
  p_sub_bound_r6: assert property (@(posedge clk) disable iff (rst)
    stat.eValid |-> (execSub <= lastSubOf(stat.eCls)));

  // R4: data-processing never shows a second execute cycle
  p_alu_single_r4: assert property (@(posedge clk) disable iff (rst)
    (stat.eValid && stat.eCls == CLS_ALU) |-> (execSub == '0));

  // R7: the target is presented right after the calculation cycle
  p_flush_follows_calc_r7: assert property (@(posedge clk) disable iff (rst)
    ctrl.flush |-> $past(ctrl.redirect));

  // R8: link write only for a branch in execute
  p_link_only_branch_r8: assert property (@(posedge clk) disable iff (rst)
    ctrl.linkWr |-> (stat.eValid && stat.eCls == CLS_BRANCH && ctrl.decAccept));

endmodule

// File: rtl/pipe3_seq.sv
module pipe3_seq
  import seq3_pkg::*;
#(
  parameter int IW          = 16,
  parameter int AW          = 16,
  parameter int OFFW        = 8,
  parameter int INSTR_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IW-1:0]    instrWord,
  output logic [AW-1:0]    fetchAddr,
  output logic             fetchEn,
  output logic             decodeValid,
  output logic             execValid,
  output logic [SUB_W-1:0] execSub,
  output logic             linkWrite,
  output logic             flush
);

  seq_ctrl_t ctrl;
  seq_stat_t stat;

  seq3_datapath #(
    .IW(IW), .AW(AW), .OFFW(OFFW), .INSTR_BYTES(INSTR_BYTES)
  ) u_dp (
    .clk(clk), .rst(rst), .instrWord(instrWord),
    .ctrl(ctrl), .stat(stat), .fetchAddr(fetchAddr)
  );

  seq3_control u_ctl (
    .clk(clk), .rst(rst), .stat(stat), .ctrl(ctrl),
    .execSub(execSub), .fetchEn(fetchEn)
  );

  assign decodeValid = stat.dValid;
  assign execValid   = stat.eValid;
  assign linkWrite   = ctrl.linkWr;
  assign flush       = ctrl.flush;

endmodule

// File: tb/pipe3_seq_tb.sv
module pipe3_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instrWord;
  logic [15:0] fetchAddr;
  logic        fetchEn, decodeValid, execValid, linkWrite, flush;
  logic [1:0]  execSub;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pipe3_seq u_dut (
    .clk(clk), .rst(rst), .instrWord(instrWord), .fetchAddr(fetchAddr),
    .fetchEn(fetchEn), .decodeValid(decodeValid), .execValid(execValid),
    .execSub(execSub), .linkWrite(linkWrite), .flush(flush)
  );

  // stimulus table: {instruction word, expected execute cycles}
  localparam logic [19:0] PROG [0:15] = '{
    {16'h0000, 4'd1},  // 0  data-processing
    {16'h4000, 4'd2},  // 1  store
    {16'h0011, 4'd1},  // 2  data-processing
    {16'h8000, 4'd3},  // 3  load
    {16'hC004, 4'd3},  // 4  branch +4 -> 8
    {16'h0005, 4'd1},  // 5  discarded
    {16'h8006, 4'd3},  // 6  discarded
    {16'h4007, 4'd2},  // 7
    {16'hC004, 4'd3},  // 8  branch +4 -> 12 (target of a branch)
    {16'h8009, 4'd3},  // 9  discarded
    {16'h000A, 4'd1},  // 10
    {16'h000B, 4'd1},  // 11
    {16'h000C, 4'd1},  // 12 data-processing
    {16'h000D, 4'd1},  // 13 data-processing
    {16'h800E, 4'd3},  // 14 load
    {16'hC0F1, 4'd3}   // 15 branch -15 -> 0
  };

  function automatic logic [15:0] wordAt(logic [15:0] a);
    if (a[15:2] < 14'd16) return PROG[a[5:2]][19:4];
    return 16'h0000;
  endfunction

  function automatic int cyclesAt(logic [15:0] a);
    if (a[15:2] < 14'd16) return int'(PROG[a[5:2]][3:0]);
    return 1;
  endfunction

  assign instrWord = wordAt(fetchAddr);

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  // reference model state
  logic [15:0] mFa, mDa, mEa;
  bit          mDv, mEv;
  int          mEs;
  int          flushSeen, branchRetired;

  initial begin
    bit busy, brE1, brE2, expFe, isBr;
    logic [15:0] tgt, w;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check(fetchAddr == 16'h0 && !decodeValid && !execValid && !fetchEn, "R1",
          $sformatf("reset state fa=%h dv=%b ev=%b fe=%b exp 0/0/0/0",
                    fetchAddr, decodeValid, execValid, fetchEn));
    @(negedge clk);
    rst = 1'b0;
    mFa = 16'h0; mDa = 16'h0; mEa = 16'h0; mDv = 0; mEv = 0; mEs = 0;
    flushSeen = 0; branchRetired = 0;

    for (int cyc = 0; cyc < 150; cyc++) begin
      #1;
      w    = wordAt(mEa);
      isBr = mEv && (w[15:14] == 2'b11);
      busy = mEv && (mEs < cyclesAt(mEa) - 1);
      brE1 = isBr && mEs == 0;
      brE2 = isBr && mEs == 1;
      expFe = !(busy && mDv);
      tgt  = mEa + ({{8{w[7]}}, w[7:0]} << 2);

      check(fetchAddr == mFa && fetchEn == expFe && decodeValid == mDv &&
            execValid == mEv && (!mEv || execSub == 2'(mEs)) &&
            linkWrite == brE2 && flush == brE2,
            "R2 R4 R5 R6 R7 R8",
            $sformatf("cyc %0d got fa=%h fe=%b dv=%b ev=%b es=%0d lw=%b fl=%b exp fa=%h fe=%b dv=%b ev=%b es=%0d lw=%b fl=%b",
                      cyc, fetchAddr, fetchEn, decodeValid, execValid, execSub,
                      linkWrite, flush, mFa, expFe, mDv, mEv, mEs, brE2, brE2));

      // hand-derived corner checks
      if (cyc == 3)
        check(!fetchEn && fetchAddr == 16'd12, "R5",
              $sformatf("store hold fe=%b fa=%0d exp 0/12", fetchEn, fetchAddr));
      if (cyc == 10)
        check(flush && linkWrite && fetchAddr == 16'd32 && !decodeValid, "R7",
              $sformatf("branch restart fl=%b lw=%b fa=%0d dv=%b exp 1/1/32/0",
                        flush, linkWrite, fetchAddr, decodeValid));
      if (cyc == 13)
        check(flush && fetchAddr == 16'd48, "R9",
              $sformatf("back-to-back branch fl=%b fa=%0d exp 1/48", flush, fetchAddr));
      if (cyc == 11)
        check(fetchAddr == 16'd36 && decodeValid, "R3",
              $sformatf("target+4 fa=%0d dv=%b exp 36/1", fetchAddr, decodeValid));

      if (flush) flushSeen++;
      if (isBr && mEs == 2) branchRetired++;

      // advance model one cycle
      if (brE1) begin
        mFa = tgt;
        mDv = 0;
        mEs++;
      end else begin
        if (!busy) begin
          mEv = mDv; mEa = mDa; mEs = 0;
        end else begin
          mEs++;
        end
        if (expFe) begin
          mDa = mFa; mDv = 1; mFa = mFa + 16'd4;
        end
      end
      @(negedge clk);
    end

    check(flushSeen >= branchRetired && branchRetired > 3, "R8",
          $sformatf("flush count %0d branches retired %0d", flushSeen, branchRetired));

    // reset in the middle of a run
    rst = 1'b1;
    @(negedge clk);
    #1;
    check(fetchAddr == 16'h0 && !decodeValid && !execValid && !fetchEn, "R1",
          $sformatf("mid-run reset fa=%h dv=%b ev=%b fe=%b exp 0/0/0/0",
                    fetchAddr, decodeValid, execValid, fetchEn));
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(fetchEn && fetchAddr == 16'h0, "R1",
          $sformatf("first cycle after release fe=%b fa=%h exp 1/0", fetchEn, fetchAddr));
    @(negedge clk);
    #1;
    check(fetchEn && fetchAddr == 16'd4 && decodeValid && !execValid, "R2",
          $sformatf("second cycle fe=%b fa=%0d dv=%b ev=%b exp 1/4/1/0",
                    fetchEn, fetchAddr, decodeValid, execValid));
    @(negedge clk);
    #1;
    check(fetchAddr == 16'd8 && execValid && execSub == 2'd0, "R4",
          $sformatf("first execute fa=%0d ev=%b es=%0d exp 8/1/0",
                    fetchAddr, execValid, execSub));
    finishRun();
  end

endmodule